// File: doc/BRIEF.md
# Subcarrier Edge-Counting Frame Receiver

This block receives a card-to-reader frame whose length the reader already knows, from 1 to 16 bits. The frame has no start or stop markers. The only timing reference is a start pulse, which the surrounding logic raises when its own outgoing frame ends. The block takes a thresholded demodulator level, synchronizes it, and counts its transitions inside fixed, back-to-back bit windows. A window with a transition count inside a fixed band means the subcarrier was present, so that bit is a '1'. Any other count, including a silent window, gives a '0'.

When ciphering is enabled, the decoded bits are XORed with keystream bits taken from an external generator. The block collects these bits in the quiet gap before the first window opens. It drives a step pulse to advance the generator and samples the generator's current bit before each step. Time is counted in ticks, which are the clock cycles where the tick enable is high. A silent card and an absent card give the same all-zero result, and no error is raised.

Top module: `edge_count_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, data_out is 0, done is 0 and ks_step is 0. Without a start pulse the block stays idle and issues no ks_step.
- R2: A bit_count of 0 is treated as 1. A bit_count above 16 is treated as 16. The effective count fixes both the number of windows and the number of cipher bits.
- R3: The first bit window opens 490 ticks after the clock edge that accepts start. Each window is 150 ticks long and follows the previous one without a gap. done rises on the clock after the final tick of the last window and never earlier. An all-silent frame also completes this way.
- R4: In each window the block counts transitions of the synchronized level. A count greater than 20 and less than 60 decodes as 1, and any other count decodes as 0. The count saturates at 63, so 70 transitions decode as 0.
- R5: Window i sets data_out bit i (bit 0 is the first window). Bits at or above the effective count read 0.
- R6: After start, exactly two ks_step pulses are issued. With crypt_en high, one more pulse follows for each frame bit. Each pulse is one cycle long with at least one idle cycle between pulses, and none are issued at any other time.
- R7: With crypt_en high, data_out bit i is the decoded bit XOR the ks_bit value present after 2+i steps. With crypt_en low, the decoded bits appear unchanged.
- R8: A start pulse while a frame is in progress is ignored. It does not change the timing, the step count or the result.
- R9: done is a one-cycle pulse. data_out changes only together with done and holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_in | input | 1 | Thresholded demodulator level (asynchronous) |
| bit_count | input | 5 | Requested frame length in bits, sampled with start |
| crypt_en | input | 1 | Enables keystream XOR, sampled with start |
| start | input | 1 | Pulse marking the end of the reader frame |
| ks_bit | input | 1 | Current keystream generator output |
| tick_en | input | 1 | Timebase tick enable |
| data_out | output | 16 | Received frame, first bit in bit 0 |
| ks_step | output | 1 | Advance request to the keystream generator |
| done | output | 1 | One-cycle pulse when data_out is updated |

## Verification
With tick_en held high, done and the new data_out appear on the clock after edge 490+150·n, where n is the effective bit count and edge 0 is the one that samples start. The bench counts exactly that many falling edges before it checks done, data_out and the running tallies of done and ks_step pulses. A transition on level_in is counted about three clocks later, after two synchronizer stages and one edge-detect stage. The bench therefore places every transition in the first 145 cycles of its 150-cycle window, so that none spills into the next window. All inputs change on the falling edge, and all outputs are sampled there, half a period away from the active edge.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_LEAD = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ecr_sync.sv
module ecr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= lvl_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign edge_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/ecr_keymask.sv
module ecr_keymask #(
  parameter int MAX_BITS  = 16,
  parameter int PRE_STEPS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       crypt,
  input  logic [$clog2(MAX_BITS):0]  nbits,
  input  logic                       ks_bit,
  output logic                       ks_step,
  output logic [MAX_BITS-1:0]        mask
);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int PRE_W = $clog2(PRE_STEPS + 1);

  logic             active;
  logic             phase;
  logic [PRE_W-1:0] pre_left;
  logic [IDX_W:0]   col_left;
  logic [IDX_W-1:0] idx;

  // Each step takes two cycles: pulse, then a gap so the generator
  // output settles before the next sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      pre_left <= '0;
      col_left <= '0;
      idx      <= '0;
      mask     <= '0;
      ks_step  <= 1'b0;
    end else if (load) begin
      active   <= 1'b1;
      phase    <= 1'b0;
      pre_left <= PRE_W'(PRE_STEPS);
      col_left <= crypt ? nbits : '0;
      idx      <= '0;
      mask     <= '0;
      ks_step  <= 1'b0;
    end else if (active) begin
      if (!phase) begin
        if (pre_left != '0) begin
          pre_left <= pre_left - PRE_W'(1);
          ks_step  <= 1'b1;
          phase    <= 1'b1;
        end else if (col_left != '0) begin
          mask[idx] <= ks_bit;
          idx       <= idx + IDX_W'(1);
          col_left  <= col_left - (IDX_W+1)'(1);
          ks_step   <= 1'b1;
          phase     <= 1'b1;
        end else begin
          active <= 1'b0;
        end
      end else begin
        ks_step <= 1'b0;
        phase   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecr_window.sv
module ecr_window #(
  parameter int WAIT_TICKS = 490,
  parameter int BIT_TICKS  = 150,
  parameter int EDGE_W     = 6,
  parameter int EDGE_LO    = 20,
  parameter int EDGE_HI    = 60,
  parameter int MAX_BITS   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       accept,
  input  logic                       tick_en,
  input  logic                       edge_i,
  input  logic [$clog2(MAX_BITS):0]  nbits_in,
  output logic                       busy,
  output logic                       bit_ok,
  output logic                       bit_dec,
  output logic [$clog2(MAX_BITS)-1:0] bit_idx,
  output logic                       bit_last
);
  import ecr_pkg::*;

  localparam int IDX_W  = $clog2(MAX_BITS);
  localparam int TMAX   = max_of(WAIT_TICKS, BIT_TICKS);
  localparam int TCNT_W = $clog2(TMAX);
  localparam logic [TCNT_W-1:0] LEAD_END = TCNT_W'(WAIT_TICKS - 1);
  localparam logic [TCNT_W-1:0] BIT_END  = TCNT_W'(BIT_TICKS - 1);
  localparam logic [EDGE_W-1:0] E_MAX    = '1;
  localparam logic [EDGE_W-1:0] E_LO     = EDGE_W'(EDGE_LO);
  localparam logic [EDGE_W-1:0] E_HI     = EDGE_W'(EDGE_HI);

  rx_state_e         state;
  logic [TCNT_W-1:0] tcnt;
  logic [EDGE_W-1:0] ecnt;
  logic [EDGE_W-1:0] ecnt_next;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    nb_q;

  always_comb begin
    ecnt_next = ecnt;
    if (edge_i && (ecnt != E_MAX)) ecnt_next = ecnt + EDGE_W'(1);
  end

  assign busy     = (state != RX_IDLE);
  assign bit_ok   = (state == RX_BITS) && tick_en && (tcnt == BIT_END);
  assign bit_dec  = (ecnt_next > E_LO) && (ecnt_next < E_HI);
  assign bit_idx  = idx;
  assign bit_last = bit_ok && (({1'b0, idx} + (IDX_W+1)'(1)) == nb_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      ecnt  <= '0;
      idx   <= '0;
      nb_q  <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (accept) begin
            state <= RX_LEAD;
            tcnt  <= '0;
            ecnt  <= '0;
            idx   <= '0;
            nb_q  <= nbits_in;
          end
        end
        RX_LEAD: begin
          if (tick_en) begin
            if (tcnt == LEAD_END) begin
              state <= RX_BITS;
              tcnt  <= '0;
              ecnt  <= '0;
            end else begin
              tcnt <= tcnt + TCNT_W'(1);
            end
          end
        end
        RX_BITS: begin
          ecnt <= ecnt_next;
          if (tick_en) begin
            if (tcnt == BIT_END) begin
              tcnt <= '0;
              ecnt <= '0;
              if (bit_last) state <= RX_IDLE;
              else          idx   <= idx + IDX_W'(1);
            end else begin
              tcnt <= tcnt + TCNT_W'(1);
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edge_count_rx.sv
module edge_count_rx #(
  parameter int MAX_BITS    = 16,
  parameter int WAIT_TICKS  = 490,
  parameter int BIT_TICKS   = 150,
  parameter int EDGE_W      = 6,
  parameter int EDGE_LO     = 20,
  parameter int EDGE_HI     = 60,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_STEPS   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        level_in,
  input  logic [$clog2(MAX_BITS):0]   bit_count,
  input  logic                        crypt_en,
  input  logic                        start,
  input  logic                        ks_bit,
  input  logic                        tick_en,
  output logic [MAX_BITS-1:0]         data_out,
  output logic                        ks_step,
  output logic                        done
);
  localparam int IDX_W  = $clog2(MAX_BITS);
  localparam int BCNT_W = IDX_W + 1;
  localparam logic [BCNT_W-1:0] N_MAX = BCNT_W'(MAX_BITS);

  logic                edge_w;
  logic                busy;
  logic                accept;
  logic [BCNT_W-1:0]   nb_eff;
  logic                bit_ok;
  logic                bit_dec;
  logic [IDX_W-1:0]    bit_idx;
  logic                bit_last;
  logic [MAX_BITS-1:0] mask;
  logic [MAX_BITS-1:0] acc;
  logic [MAX_BITS-1:0] acc_next;

  assign accept = start && !busy;

  always_comb begin
    if (bit_count == '0)        nb_eff = BCNT_W'(1);
    else if (bit_count > N_MAX) nb_eff = N_MAX;
    else                        nb_eff = bit_count;
  end

  ecr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .lvl_in (level_in),
    .edge_o (edge_w)
  );

  ecr_window #(
    .WAIT_TICKS (WAIT_TICKS),
    .BIT_TICKS  (BIT_TICKS),
    .EDGE_W     (EDGE_W),
    .EDGE_LO    (EDGE_LO),
    .EDGE_HI    (EDGE_HI),
    .MAX_BITS   (MAX_BITS)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .tick_en  (tick_en),
    .edge_i   (edge_w),
    .nbits_in (nb_eff),
    .busy     (busy),
    .bit_ok   (bit_ok),
    .bit_dec  (bit_dec),
    .bit_idx  (bit_idx),
    .bit_last (bit_last)
  );

  ecr_keymask #(
    .MAX_BITS  (MAX_BITS),
    .PRE_STEPS (PRE_STEPS)
  ) u_key (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .crypt   (crypt_en),
    .nbits   (nb_eff),
    .ks_bit  (ks_bit),
    .ks_step (ks_step),
    .mask    (mask)
  );

  always_comb begin
    acc_next          = acc;
    acc_next[bit_idx] = bit_dec ^ mask[bit_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        acc <= '0;
      end else if (bit_ok) begin
        acc <= acc_next;
        if (bit_last) begin
          data_out <= acc_next;
          done     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecr_chk.sv
module ecr_chk #(
  parameter int MAX_BITS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                done,
  input logic                ks_step,
  input logic [MAX_BITS-1:0] data_out
);
  // R1: outputs are quiet right after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !ks_step && data_out == '0));

  // R3: done only follows a cycle in which a frame was running
  assert_done_after_frame_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R6: step pulses are single cycles separated by a gap
  assert_ks_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ks_step |=> !ks_step);

  // R6: no stepping at the end of a frame
  assert_ks_quiet_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !ks_step);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: result changes only with done
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(data_out));
endmodule

bind edge_count_rx ecr_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .ks_step  (ks_step),
  .data_out (data_out)
);

// File: tb/sim_edge_count_rx.sv
`timescale 1ns/1ps
module sim_edge_count_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        level_in = 1'b0;
  logic [4:0]  bit_count = '0;
  logic        crypt_en = 1'b0;
  logic        start = 1'b0;
  logic        ks_bit;
  logic        tick_en = 1'b1;
  logic [15:0] data_out;
  logic        ks_step;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  int ks_cnt  = 0;
  int dn_cnt  = 0;
  logic [6:0] lfsr;

  always #4 clk = ~clk;

  edge_count_rx u0 (
    .clk(clk), .rst(rst), .level_in(level_in), .bit_count(bit_count),
    .crypt_en(crypt_en), .start(start), .ks_bit(ks_bit), .tick_en(tick_en),
    .data_out(data_out), .ks_step(ks_step), .done(done)
  );

  function automatic logic [6:0] lf_step(input logic [6:0] s);
    return {s[0] ^ s[1], s[6:1]};
  endfunction

  // keystream model driven only by the step pulse
  always_ff @(posedge clk) begin
    if (rst)          lfsr <= 7'h55;
    else if (ks_step) lfsr <= lf_step(lfsr);
  end
  assign ks_bit = lfsr[0];

  always @(posedge clk) begin
    if (ks_step) ks_cnt <= ks_cnt + 1;
    if (done)    dn_cnt <= dn_cnt + 1;
  end

  function automatic logic [15:0] ks_expect(input logic [6:0] s0, input int n, input bit cr);
    logic [6:0]  s = s0;
    logic [15:0] m = '0;
    s = lf_step(s);
    s = lf_step(s);
    if (cr) begin
      for (int i = 0; i < n; i++) begin
        m[i] = s[0];
        s = lf_step(s);
      end
    end
    return m;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_frame(input int nb_req, input bit cr, input int cnts [16],
                           input logic [15:0] plain, input bit glitch, input string tag);
    int n_eff;
    int ks0, d0;
    logic [15:0] km, expv, lim;
    n_eff = (nb_req == 0) ? 1 : ((nb_req > 16) ? 16 : nb_req);
    @(negedge clk);
    bit_count = 5'(nb_req);
    crypt_en  = cr;
    start     = 1'b1;
    km   = ks_expect(lfsr, n_eff, cr);
    lim  = 16'((32'h1 << n_eff) - 1);
    expv = (plain ^ km) & lim;
    ks0 = ks_cnt;
    d0  = dn_cnt;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 490; k++) begin
      start = (glitch && (k == 100 || k == 300)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    for (int w = 0; w < n_eff; w++) begin
      for (int j = 0; j < 150; j++) begin
        if (j >= 4 && j < 4 + 2 * cnts[w] && ((j - 4) % 2 == 0)) level_in = ~level_in;
        if (glitch && w == 0 && j == 50) start = 1'b1;
        else start = 1'b0;
        @(negedge clk);
      end
    end
    chk(done == 1'b1, "R3", {tag, " done on time"}, int'(done), 1);
    chk(dn_cnt - d0 == 0, "R3", {tag, " no early done"}, dn_cnt - d0, 0);
    chk(data_out == expv, tag, "data_out", int'(data_out), int'(expv));
    chk(ks_cnt - ks0 == 2 + (cr ? n_eff : 0), "R6", {tag, " step count"},
        ks_cnt - ks0, 2 + (cr ? n_eff : 0));
    @(negedge clk);
    chk(done == 1'b0, "R9", {tag, " done one cycle"}, int'(done), 0);
    chk(data_out == expv, "R9", {tag, " data held"}, int'(data_out), int'(expv));
  endtask

  // {bit_count, crypt_en, pattern}
  localparam logic [21:0] VEC [6] = '{
    {5'd8,  1'b0, 16'h00A5},
    {5'd1,  1'b0, 16'h0001},
    {5'd16, 1'b0, 16'h8001},
    {5'd12, 1'b1, 16'h0F0F},
    {5'd5,  1'b1, 16'h0000},
    {5'd7,  1'b0, 16'h0000}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin : main
    int cnt_a [16];
    repeat (3) @(negedge clk);
    chk(data_out == 16'h0 && done == 1'b0 && ks_step == 1'b0, "R1", "in reset",
        int'({data_out, done, ks_step}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(data_out == 16'h0 && done == 1'b0 && ks_step == 1'b0, "R1", "after reset",
        int'({data_out, done, ks_step}), 0);
    repeat (20) @(negedge clk);
    chk(ks_cnt == 0 && dn_cnt == 0, "R1", "idle without start", ks_cnt + dn_cnt, 0);

    // table-driven frames: R5 plain ordering, R7 ciphered
    for (int v = 0; v < 6; v++) begin
      logic [15:0] pat;
      pat = VEC[v][15:0];
      for (int i = 0; i < 16; i++)
        cnt_a[i] = pat[i] ? ((i % 2 == 1) ? 50 : 30) : ((i % 3 == 0) ? 0 : 8);
      run_frame(int'(VEC[v][21:17]), VEC[v][16], cnt_a, pat, 1'b0,
                VEC[v][16] ? "R7" : "R5");
    end

    // R4: band edges and saturation
    cnt_a = '{0, 20, 21, 42, 59, 60, 61, 70, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(8, 1'b0, cnt_a, 16'h001C, 1'b0, "R4");

    // R2: oversize request clamps to 16 windows
    for (int i = 0; i < 16; i++) cnt_a[i] = 42;
    run_frame(20, 1'b0, cnt_a, 16'hFFFF, 1'b0, "R2");

    // R2: zero request becomes one window
    run_frame(0, 1'b1, cnt_a, 16'h0001, 1'b0, "R2");

    // R8: start pulses during a frame are ignored
    cnt_a = '{42, 0, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(3, 1'b1, cnt_a, 16'h0005, 1'b1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule